// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This block settles every control-transfer and compare-and-trap instruction of a 32-bit RISC pipeline that has one branch delay slot. A decode stage hands it the instruction class, the sub-code field, both source register values, the sign-extended offset/immediate, the 26-bit jump index, the destination register number, the hazard hint bit and the address of the delay-slot instruction. One clock later it reports whether control transfers, the address to fetch next, whether a link register is written and with what, whether the delay slot must be squashed, and whether a trap is requested.

The class input selects one of three sub-code spaces: the primary opcode, the register-immediate group (sub-code taken from the rt field), and the register function group. Conditional branches, likely branches, linking branches and immediate traps share the register-immediate decoder; all compares go through one condition evaluator. Fetch and exception vectoring live elsewhere.

Top module: `br_resolve_unit`

## Requirements
- R1: While reset is high and in any cycle after an edge where in_valid was low, res_valid, taken, link_en, annul, trap and hazard_barrier are all 0; a request sampled with in_valid high yields res_valid high exactly one clock later.
- R2: With class 0 (primary), sub-code 2 is an unconditional jump and 3 a jump-and-link; both are taken with next_pc = {slot_pc[31:28], jump_index, 2'b00}.
- R3: With class 2 (function group), sub-code 0x08 jumps to rs_val with bit 0 cleared and 0x09 does the same while linking; hazard_barrier is 1 exactly for these two when hint is 1.
- R4: Class 0 sub-codes 4, 5, 6, 7 branch when rs==rt, rs!=rt, rs<=0 signed, rs>0 signed; a taken branch goes to slot_pc + (offset << 2).
- R5: With class 1 (register-immediate), sub-codes 0 and 1 branch when rs<0 and rs>=0 (signed); sub-codes 2 and 3 are the likely forms of the same tests.
- R6: Likely forms (class 0 sub-codes 0x14 to 0x17, class 1 sub-codes 2, 3, 0x12, 0x13) raise annul only when not taken; a taken likely branch leaves annul at 0.
- R7: When no transfer is taken (not-taken branch, trap, unknown code), next_pc = slot_pc + 4.
- R8: Class 1 sub-codes 0x10 to 0x13 and class 0 sub-code 3 set link_en with link_reg 31, and class 2 sub-code 0x09 sets link_en with link_reg = rd_idx, whether or not the condition holds; link_val = slot_pc + 4. No other code sets link_en.
- R9: Class 1 sub-codes 0x08, 0x09, 0x0A, 0x0B, 0x0C, 0x0E request a trap when rs >= imm signed, >= unsigned, < signed, < unsigned, == and != respectively; traps never set taken.
- R10: Class 2 sub-codes 0x30, 0x31, 0x32, 0x33, 0x34, 0x36 apply the same six compares of rs against rt.
- R11: Unsigned compares use raw bit patterns, with the immediate sign-extended before comparison (an immediate of all ones is the largest unsigned value).
- R12: Undefined sub-codes (e.g. class 1 sub-code 0x0D, class 2 sub-code 0x35) and class 3 produce no taken, link, annul, trap or barrier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op_class | input | 2 | 0 primary, 1 register-immediate, 2 function group, 3 none |
| sub_code | input | 6 | Opcode, rt field or function field, by class |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| imm_sx | input | 32 | Sign-extended 16-bit offset / immediate |
| jump_index | input | 26 | Absolute jump index |
| slot_pc | input | 32 | Address of the delay-slot instruction |
| rd_idx | input | 5 | Destination register for register jump-and-link |
| hint | input | 1 | Hazard-barrier hint for register jumps |
| res_valid | output | 1 | Result present |
| taken | output | 1 | Control transfer taken |
| next_pc | output | 32 | Next fetch address |
| link_en | output | 1 | Link register write enable |
| link_reg | output | 5 | Link register number |
| link_val | output | 32 | Link value |
| annul | output | 1 | Squash the delay-slot instruction |
| trap | output | 1 | Trap request |
| hazard_barrier | output | 1 | Register jump with hazard barrier |

## Verification
The assertions watch on every cycle that idle cycles carry no flags, that taken and trap never coincide, that annul only accompanies a non-taken result, that a non-taken result falls through to slot_pc + 4, that any link carries slot_pc + 4, and that taken targets have bit 0 clear. Which sub-code maps to which condition, the signed versus unsigned split, the region-preserving jump target, the branch offset arithmetic and the rejection of undefined codes can only be shown by the bench scenarios, which compare every output against an independent reference computation over random and directed operands.

// File: rtl/bju_pkg.sv
package bju_pkg;

    localparam int unsigned XW   = 32;  // data / address width
    localparam int unsigned JW   = 26;  // jump index width
    localparam int unsigned RW   = 5;   // register number width
    localparam int unsigned SW   = 6;   // sub-code width
    localparam int unsigned RGNW = XW - JW - 2;  // preserved region bits
    localparam logic [RW-1:0] LINK_REG = RW'(31);
    localparam logic [XW-1:0] INSN_BYTES = XW'(4);

    typedef enum logic [1:0] {
        CLS_PRIMARY = 2'd0,
        CLS_REGIMM  = 2'd1,
        CLS_FUNC    = 2'd2,
        CLS_NONE    = 2'd3
    } op_class_e;

    typedef enum logic [3:0] {
        CND_NEVER, CND_ALWAYS, CND_EQ, CND_NE, CND_LEZ, CND_GTZ,
        CND_LTZ, CND_GEZ, CND_GE, CND_GEU, CND_LT, CND_LTU
    } cond_e;

    typedef enum logic [2:0] {
        ACT_NONE, ACT_BRANCH, ACT_JABS, ACT_JREG, ACT_TRAP
    } act_e;

    typedef struct packed {
        act_e  act;
        cond_e cond;
        logic  use_imm;
        logic  likely;
        logic  link;
        logic  link_rd;
    } ctl_t;

    typedef struct packed {
        logic          valid;
        logic          taken;
        logic [XW-1:0] next_pc;
        logic          link_en;
        logic [RW-1:0] link_reg;
        logic [XW-1:0] link_val;
        logic          annul;
        logic          trap;
        logic          barrier;
    } res_t;

    localparam ctl_t CTL_IDLE = '{act: ACT_NONE, cond: CND_NEVER, use_imm: 1'b0,
                                  likely: 1'b0, link: 1'b0, link_rd: 1'b0};

    // primary conditional branches, low two opcode bits
    function automatic cond_e prim_cond(input logic [1:0] sel);
        case (sel)
            2'd0:    return CND_EQ;
            2'd1:    return CND_NE;
            2'd2:    return CND_LEZ;
            default: return CND_GTZ;
        endcase
    endfunction

    // trap compare selected by low three sub-code bits; 5 and 7 are holes
    function automatic cond_e trap_cond(input logic [2:0] sel);
        case (sel)
            3'd0:    return CND_GE;
            3'd1:    return CND_GEU;
            3'd2:    return CND_LT;
            3'd3:    return CND_LTU;
            3'd4:    return CND_EQ;
            3'd6:    return CND_NE;
            default: return CND_NEVER;
        endcase
    endfunction

endpackage

// File: rtl/bju_decode.sv
module bju_decode
    import bju_pkg::*;
(
    input  op_class_e     cls,
    input  logic [SW-1:0] sub,
    output ctl_t          ctl
);
    always_comb begin
        ctl = CTL_IDLE;
        unique case (cls)
            CLS_PRIMARY: begin
                if (sub == SW'(2) || sub == SW'(3)) begin
                    ctl.act  = ACT_JABS;
                    ctl.cond = CND_ALWAYS;
                    ctl.link = sub[0];
                end else if (sub[SW-1:2] == 4'b0001 || sub[SW-1:2] == 4'b0101) begin
                    ctl.act    = ACT_BRANCH;
                    ctl.cond   = prim_cond(sub[1:0]);
                    ctl.likely = sub[4];
                end
            end
            CLS_REGIMM: begin
                if (sub[SW-1:2] == 4'b0000 || sub[SW-1:2] == 4'b0100) begin
                    ctl.act    = ACT_BRANCH;
                    ctl.cond   = sub[0] ? CND_GEZ : CND_LTZ;
                    ctl.likely = sub[1];
                    ctl.link   = sub[4];
                end else if (sub[SW-1:3] == 3'b001 && trap_cond(sub[2:0]) != CND_NEVER) begin
                    ctl.act     = ACT_TRAP;
                    ctl.cond    = trap_cond(sub[2:0]);
                    ctl.use_imm = 1'b1;
                end
            end
            CLS_FUNC: begin
                if (sub == SW'(8) || sub == SW'(9)) begin
                    ctl.act     = ACT_JREG;
                    ctl.cond    = CND_ALWAYS;
                    ctl.link    = sub[0];
                    ctl.link_rd = sub[0];
                end else if (sub[SW-1:3] == 3'b110 && trap_cond(sub[2:0]) != CND_NEVER) begin
                    ctl.act  = ACT_TRAP;
                    ctl.cond = trap_cond(sub[2:0]);
                end
            end
            default: ctl = CTL_IDLE;
        endcase
    end
endmodule

// File: rtl/bju_cond.sv
module bju_cond
    import bju_pkg::*;
(
    input  cond_e         cond,
    input  logic [XW-1:0] a,
    input  logic [XW-1:0] b,
    output logic          hit
);
    logic eq, lt_s, lt_u, a_neg, a_zero;

    always_comb begin
        eq     = (a == b);
        lt_s   = ($signed(a) < $signed(b));
        lt_u   = (a < b);
        a_neg  = a[XW-1];
        a_zero = (a == '0);
        unique case (cond)
            CND_ALWAYS: hit = 1'b1;
            CND_EQ:     hit = eq;
            CND_NE:     hit = !eq;
            CND_LEZ:    hit = a_neg || a_zero;
            CND_GTZ:    hit = !a_neg && !a_zero;
            CND_LTZ:    hit = a_neg;
            CND_GEZ:    hit = !a_neg;
            CND_GE:     hit = !lt_s;
            CND_GEU:    hit = !lt_u;
            CND_LT:     hit = lt_s;
            CND_LTU:    hit = lt_u;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bju_target.sv
module bju_target
    import bju_pkg::*;
(
    input  act_e          act,
    input  logic [XW-1:0] slot_pc,
    input  logic [XW-1:0] imm_sx,
    input  logic [JW-1:0] jump_index,
    input  logic [XW-1:0] rs_val,
    output logic [XW-1:0] target,
    output logic [XW-1:0] seq_pc
);
    logic [XW-1:0] rel_tgt, abs_tgt, reg_tgt;

    always_comb begin
        seq_pc  = slot_pc + INSN_BYTES;
        rel_tgt = slot_pc + {imm_sx[XW-3:0], 2'b00};
        abs_tgt = {slot_pc[XW-1 -: RGNW], jump_index, 2'b00};
        reg_tgt = {rs_val[XW-1:1], 1'b0};
        unique case (act)
            ACT_JABS: target = abs_tgt;
            ACT_JREG: target = reg_tgt;
            default:  target = rel_tgt;
        endcase
    end
endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit
    import bju_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    op_class,
    input  logic [SW-1:0] sub_code,
    input  logic [XW-1:0] rs_val,
    input  logic [XW-1:0] rt_val,
    input  logic [XW-1:0] imm_sx,
    input  logic [JW-1:0] jump_index,
    input  logic [XW-1:0] slot_pc,
    input  logic [RW-1:0] rd_idx,
    input  logic          hint,
    output logic          res_valid,
    output logic          taken,
    output logic [XW-1:0] next_pc,
    output logic          link_en,
    output logic [RW-1:0] link_reg,
    output logic [XW-1:0] link_val,
    output logic          annul,
    output logic          trap,
    output logic          hazard_barrier
);
    ctl_t          ctl;
    logic          hit;
    logic [XW-1:0] target, seq_pc, operand_b;
    res_t          nxt, q;

    bju_decode u_dec (
        .cls (op_class_e'(op_class)),
        .sub (sub_code),
        .ctl (ctl)
    );

    assign operand_b = ctl.use_imm ? imm_sx : rt_val;

    bju_cond u_cond (
        .cond (ctl.cond),
        .a    (rs_val),
        .b    (operand_b),
        .hit  (hit)
    );

    bju_target u_tgt (
        .act        (ctl.act),
        .slot_pc    (slot_pc),
        .imm_sx     (imm_sx),
        .jump_index (jump_index),
        .rs_val     (rs_val),
        .target     (target),
        .seq_pc     (seq_pc)
    );

    always_comb begin
        logic xfer;
        xfer         = (ctl.act == ACT_BRANCH || ctl.act == ACT_JABS ||
                        ctl.act == ACT_JREG) && hit;
        nxt.valid    = in_valid;
        nxt.taken    = in_valid && xfer;
        nxt.next_pc  = xfer ? target : seq_pc;
        nxt.link_en  = in_valid && ctl.link;
        nxt.link_reg = ctl.link_rd ? rd_idx : LINK_REG;
        nxt.link_val = seq_pc;
        nxt.annul    = in_valid && ctl.likely && !hit;
        nxt.trap     = in_valid && (ctl.act == ACT_TRAP) && hit;
        nxt.barrier  = in_valid && (ctl.act == ACT_JREG) && hint;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign res_valid      = q.valid;
    assign taken          = q.taken;
    assign next_pc        = q.next_pc;
    assign link_en        = q.link_en;
    assign link_reg       = q.link_reg;
    assign link_val       = q.link_val;
    assign annul          = q.annul;
    assign trap           = q.trap;
    assign hazard_barrier = q.barrier;
endmodule

// File: rtl/bju_checker.sv
module bju_checker
    import bju_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [XW-1:0] slot_pc,
    input logic          res_valid,
    input logic          taken,
    input logic [XW-1:0] next_pc,
    input logic          link_en,
    input logic [XW-1:0] link_val,
    input logic          annul,
    input logic          trap,
    input logic          hazard_barrier
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !res_valid);

    assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (res_valid == $past(in_valid)));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !(taken || link_en || annul || trap || hazard_barrier));

    assert_trap_not_taken_R9: assert property (@(posedge clk) disable iff (rst)
        trap |-> !taken);

    assert_annul_only_untaken_R6: assert property (@(posedge clk) disable iff (rst)
        annul |-> !taken);

    assert_fallthrough_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !taken && !$past(rst)) |-> (next_pc == $past(slot_pc) + INSN_BYTES));

    assert_link_value_R8: assert property (@(posedge clk) disable iff (rst)
        (link_en && !$past(rst)) |-> (link_val == $past(slot_pc) + INSN_BYTES));

    assert_target_even_R3: assert property (@(posedge clk) disable iff (rst)
        taken |-> !next_pc[0]);
endmodule

bind br_resolve_unit bju_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .in_valid       (in_valid),
    .slot_pc        (slot_pc),
    .res_valid      (res_valid),
    .taken          (taken),
    .next_pc        (next_pc),
    .link_en        (link_en),
    .link_val       (link_val),
    .annul          (annul),
    .trap           (trap),
    .hazard_barrier (hazard_barrier)
);

// File: tb/br_resolve_unit_tb_top.sv
module br_resolve_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op_class = 2'd3;
    logic [5:0]  sub_code = '0;
    logic [31:0] rs_val = '0, rt_val = '0, imm_sx = '0, slot_pc = '0;
    logic [25:0] jump_index = '0;
    logic [4:0]  rd_idx = '0;
    logic        hint = 1'b0;
    logic        res_valid, taken, link_en, annul, trap, hazard_barrier;
    logic [31:0] next_pc, link_val;
    logic [4:0]  link_reg;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    br_resolve_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_class(op_class),
        .sub_code(sub_code), .rs_val(rs_val), .rt_val(rt_val), .imm_sx(imm_sx),
        .jump_index(jump_index), .slot_pc(slot_pc), .rd_idx(rd_idx), .hint(hint),
        .res_valid(res_valid), .taken(taken), .next_pc(next_pc), .link_en(link_en),
        .link_reg(link_reg), .link_val(link_val), .annul(annul), .trap(trap),
        .hazard_barrier(hazard_barrier)
    );

    function automatic logic tcmp(input logic [2:0] s, input logic [31:0] a, input logic [31:0] b);
        case (s)
            3'd0: return $signed(a) >= $signed(b);
            3'd1: return a >= b;
            3'd2: return $signed(a) < $signed(b);
            3'd3: return a < b;
            3'd4: return a == b;
            default: return a != b;
        endcase
    endfunction

    // reference: {taken, next_pc, link_en, link_reg, link_val, annul, trap, barrier}
    task automatic model(input logic [1:0] c, input logic [5:0] s, output logic [73:0] e, output string tag);
        logic tk = 0, le = 0, an = 0, tp = 0, br = 0, cnd;
        logic [4:0] lr = 5'd31;
        logic [31:0] pc = slot_pc + 32'd4;
        tag = "R12 undefined";
        if (c == 2'd0 && (s == 6'd2 || s == 6'd3)) begin
            tk = 1; pc = {slot_pc[31:28], jump_index, 2'b00}; le = s[0]; tag = "R2 abs jump";
        end else if (c == 2'd0 && ((s >= 6'd4 && s <= 6'd7) || (s >= 6'h14 && s <= 6'h17))) begin
            case (s[1:0])
                2'd0: cnd = rs_val == rt_val;
                2'd1: cnd = rs_val != rt_val;
                2'd2: cnd = $signed(rs_val) <= 0;
                default: cnd = $signed(rs_val) > 0;
            endcase
            tk = cnd; if (cnd) pc = slot_pc + (imm_sx << 2);
            an = s[4] && !cnd; tag = s[4] ? "R6 primary likely" : "R4 primary branch";
        end else if (c == 2'd1 && (s <= 6'd3 || (s >= 6'h10 && s <= 6'h13))) begin
            cnd = s[0] ? !rs_val[31] : rs_val[31];
            tk = cnd; if (cnd) pc = slot_pc + (imm_sx << 2);
            an = s[1] && !cnd; le = s[4];
            tag = s[4] ? "R8 linking branch" : (s[1] ? "R6 regimm likely" : "R5 regimm branch");
        end else if (c == 2'd1 && s >= 6'h08 && s <= 6'h0E && s != 6'h0D) begin
            tp = tcmp(s[2:0], rs_val, imm_sx); tag = "R9 imm trap";
        end else if (c == 2'd2 && (s == 6'h08 || s == 6'h09)) begin
            tk = 1; pc = rs_val & ~32'd1; br = hint; le = s[0];
            if (s[0]) lr = rd_idx;
            tag = "R3 reg jump";
        end else if (c == 2'd2 && s >= 6'h30 && s <= 6'h36 && s != 6'h35) begin
            tp = tcmp(s[2:0], rs_val, rt_val); tag = "R10 reg trap";
        end
        if (!tk && tag != "R12 undefined" && !le) tag = {tag, " R7"};
        e = {tk, pc, le, le ? lr : 5'd0, le ? slot_pc + 32'd4 : 32'd0, an, tp, br};
    endtask

    task automatic run_one(input logic [1:0] c, input logic [5:0] s, input string note);
        logic [73:0] exp_v, act_v;
        string tag;
        op_class = c; sub_code = s; in_valid = 1'b1;
        model(c, s, exp_v, tag);
        @(posedge clk); @(negedge clk);
        act_v = {taken, next_pc, link_en, link_en ? link_reg : 5'd0,
                 link_en ? link_val : 32'd0, annul, trap, hazard_barrier};
        checks++;
        if (!res_valid || act_v !== exp_v) begin
            errors++;
            $display("FAIL %s %s: valid=%0b act=%h exp=%h", tag, note, res_valid, act_v, exp_v);
        end
    endtask

    task automatic idle_check(input string note);
        in_valid = 1'b0; op_class = 2'd0; sub_code = 6'd2;
        @(posedge clk); @(negedge clk);
        checks++;
        if ({res_valid, taken, link_en, annul, trap, hazard_barrier} !== 6'b0) begin
            errors++;
            $display("FAIL R1 %s: act=%b exp=000000", note,
                     {res_valid, taken, link_en, annul, trap, hazard_barrier});
        end
    endtask

    function automatic logic [5:0] pick_sub(input logic [1:0] c);
        logic [5:0] r = 6'($urandom);
        if ($urandom % 8 == 0) return r;
        case (c)
            2'd0: return (r[0]) ? {1'b0, r[4], 2'b01, r[1:0]} & 6'h17 : 6'(2 + r[1] );
            2'd1: return r[1] ? {2'b00, r[2], 1'b0, r[1:0]} : {3'b001, r[4:2]};
            default: return r[0] ? 6'(8 + r[1]) : {3'b110, r[3:1]};
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: act=hung exp=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7151));
        repeat (3) @(negedge clk);
        checks++;
        if ({res_valid, taken, link_en, annul, trap, hazard_barrier} !== 6'b0) begin
            errors++;
            $display("FAIL R1 reset: act=%b exp=000000", {res_valid, taken, link_en, annul, trap, hazard_barrier});
        end
        rst = 1'b0;

        // R2: region bits kept from the slot address
        slot_pc = 32'hF000_0004; jump_index = 26'h3FF_FFFF;
        run_one(2'd0, 6'd3, "jal top region");
        // R3: odd register target, barrier hint, link to rd
        rs_val = 32'h1234_5677; hint = 1; rd_idx = 5'd7;
        run_one(2'd2, 6'h09, "jalr hint");
        hint = 0;
        run_one(2'd2, 6'h08, "jr plain");
        idle_check("after request");
        // R4: backward beq
        rs_val = 32'd5; rt_val = 32'd5; imm_sx = 32'hFFFF_FFF0; slot_pc = 32'h0000_1000;
        run_one(2'd0, 6'd4, "beq backward");
        // R6 / R7: bltzl not taken annuls
        rs_val = 32'd1;
        run_one(2'd1, 6'd2, "bltzl untaken");
        // R6: bltzl taken no annul
        rs_val = 32'h8000_0000;
        run_one(2'd1, 6'd2, "bltzl taken");
        // R8: bgezal not taken still links
        run_one(2'd1, 6'h11, "bgezal untaken link");
        // R11: unsigned compare against all-ones immediate
        rs_val = 32'd3; imm_sx = 32'hFFFF_FFFF;
        run_one(2'd1, 6'h0B, "tltiu all ones");
        run_one(2'd1, 6'h08, "tgei signed");
        rt_val = 32'h8000_0000;
        run_one(2'd2, 6'h30, "tge signed");
        run_one(2'd2, 6'h31, "tgeu unsigned");
        // R12: holes and idle class
        run_one(2'd1, 6'h0D, "regimm hole");
        run_one(2'd2, 6'h35, "func hole");
        run_one(2'd3, 6'd4, "class none");
        idle_check("end directed");

        for (int i = 0; i < 3000; i++) begin
            logic [1:0] c = 2'($urandom % 3);
            if (i % 97 == 0) c = 2'd3;
            rt_val     = $urandom;
            case ($urandom % 5)
                0: rs_val = rt_val;
                1: rs_val = '0;
                2: rs_val = 32'($signed(-($urandom % 4)));
                default: rs_val = $urandom;
            endcase
            imm_sx     = 32'($signed(16'($urandom)));
            if ($urandom % 4 == 0) imm_sx = rs_val;
            jump_index = 26'($urandom);
            slot_pc    = {$urandom, 2'b00} ;
            rd_idx     = 5'($urandom);
            hint       = 1'($urandom);
            run_one(c, pick_sub(c), "random");
            if (i % 211 == 0) idle_check("random idle");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule